// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

This block chooses which page frame receives an incoming page. It tracks a fixed set of frames, each with an occupied flag, a recently-referenced flag and a written flag. When a request arrives and at least one frame is unoccupied, the block hands that frame out at once. This is the placement path, and no scan takes place.

When every frame is occupied, a rotating pointer walks the frames one per clock. A frame whose referenced flag is set gets a second chance: the flag is cleared and the pointer moves on. The first frame found with the flag already clear becomes the victim. The block reports the victim's index and whether it was written, so that the caller knows a write-back is needed before the frame is reused.

Translation hits feed a reference port that marks a frame as referenced, and also as written on a store. A separate port releases a frame when its page is discarded. Disk transfers, page-table edits and fault handling belong to the surrounding system.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame is unoccupied with both status flags clear, the pointer is at frame 0, and `busy_o` and `done_o` are low.
- R2: A request accepted while some frame is unoccupied raises `done_o` in the cycle after the accepting edge. It reports the lowest-numbered unoccupied frame with `placed_o`=1 and `dirty_o`=0, and marks that frame occupied with both flags clear. `busy_o` stays low.
- R3: A request accepted while all frames are occupied starts a scan that examines the frame under the pointer once per cycle. A frame with its referenced flag set has the flag cleared and is passed over. The first frame with the flag clear is reported with `placed_o`=0.
- R4: The pointer steps from the last frame back to frame 0. After a victim is chosen it rests on the frame that follows the victim, and the next scan starts there.
- R5: `dirty_o` equals the victim's written flag at the moment of selection. The victim's referenced and written flags are then cleared.
- R6: A reference update sets the referenced flag of the named frame, and also the written flag when `ref_write_i` is 1. If it names the frame under the pointer in a scan cycle, the update wins: the frame counts as referenced, is passed over, and keeps its referenced flag set.
- R7: `done_o` is a single-cycle pulse. `busy_o` is high from the accepting edge of a scan until the edge that raises `done_o`. A request seen while `busy_o` or `done_o` is high is ignored.
- R8: Counting from the accepting edge, a scan that examines k frames raises `done_o` k+1 edges later, and never more than 2×N cycles after acceptance, where N is the number of frames.
- R9: A release marks the named frame unoccupied and clears both of its flags. It overrides a reference update to the same frame in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request for a frame |
| ref_en_i | input | 1 | Reference update strobe |
| ref_frame_i | input | IDX_W | Frame named by the reference update |
| ref_write_i | input | 1 | Reference was a write; also set the written flag |
| inv_en_i | input | 1 | Release strobe |
| inv_frame_i | input | IDX_W | Frame to release |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| victim_o | output | IDX_W | Chosen frame index |
| dirty_o | output | 1 | Chosen frame needs write-back |
| placed_o | output | 1 | Chosen frame was unoccupied (placement) |

## Verification
A reference update can land on the very frame the pointer clears in the same cycle. The bench provokes this by driving a reference to the pointer's frame during the first scan cycle. It then compares the reported victim and latency with a cycle-stepped model in which the update outranks the clear. A release and a reference to the same frame are also driven together, and the follow-up placement must return that frame with a clean write-back flag.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
   typedef enum logic [0:0] {
      HAND_IDLE = 1'b0,
      HAND_SCAN = 1'b1
   } hand_state_t;
endpackage

// File: rtl/cvs_frame_status.sv
module cvs_frame_status #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ref_en,
   input  logic [IDX_W-1:0]      ref_idx,
   input  logic                  ref_wr,
   input  logic                  inv_en,
   input  logic [IDX_W-1:0]      inv_idx,
   input  logic                  clr_en,
   input  logic [IDX_W-1:0]      clr_idx,
   input  logic                  claim_en,
   input  logic [IDX_W-1:0]      claim_idx,
   output logic [NUM_FRAMES-1:0] valid_vec,
   output logic [NUM_FRAMES-1:0] ref_vec,
   output logic [NUM_FRAMES-1:0] mod_vec
);
   for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
      logic v_q, r_q, m_q;
      logic hit_ref, hit_inv, hit_clr, hit_claim;

      assign hit_ref   = ref_en   && (ref_idx   == IDX_W'(g));
      assign hit_inv   = inv_en   && (inv_idx   == IDX_W'(g));
      assign hit_clr   = clr_en   && (clr_idx   == IDX_W'(g));
      assign hit_claim = claim_en && (claim_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            r_q <= 1'b0;
            m_q <= 1'b0;
         end else if (hit_inv) begin
            v_q <= 1'b0;
            r_q <= 1'b0;
            m_q <= 1'b0;
         end else begin
            if (hit_claim)
               v_q <= 1'b1;
            if (hit_ref)
               r_q <= 1'b1;
            else if (hit_claim || hit_clr)
               r_q <= 1'b0;
            if (hit_ref && ref_wr)
               m_q <= 1'b1;
            else if (hit_claim)
               m_q <= 1'b0;
         end
      end

      assign valid_vec[g] = v_q;
      assign ref_vec[g]   = r_q;
      assign mod_vec[g]   = m_q;
   end
endmodule

// File: rtl/cvs_free_pick.sv
module cvs_free_pick #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = 3
) (
   input  logic [NUM_FRAMES-1:0] valid_vec,
   output logic                  any_free,
   output logic [IDX_W-1:0]      free_idx
);
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/cvs_hand_scan.sv
module cvs_hand_scan
   import cvs_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  any_free,
   input  logic [IDX_W-1:0]      free_idx,
   input  logic [NUM_FRAMES-1:0] ref_vec,
   input  logic [NUM_FRAMES-1:0] mod_vec,
   input  logic                  ref_en,
   input  logic [IDX_W-1:0]      ref_idx,
   output logic                  clr_en,
   output logic [IDX_W-1:0]      clr_idx,
   output logic                  claim_en,
   output logic [IDX_W-1:0]      claim_idx,
   output logic                  busy,
   output logic                  done,
   output logic [IDX_W-1:0]      victim,
   output logic                  dirty,
   output logic                  placed
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

   hand_state_t      state_q;
   logic [IDX_W-1:0] hand_q, hand_next;
   logic             done_q, dirty_q, placed_q;
   logic [IDX_W-1:0] victim_q;
   logic             accept, scanning, eff_ref;

   if (NUM_FRAMES == (1 << IDX_W)) begin : g_wrap_pow2
      assign hand_next = hand_q + 1'b1;
   end else begin : g_wrap_cmp
      assign hand_next = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
   end

   assign scanning  = (state_q == HAND_SCAN);
   assign accept    = req && !scanning && !done_q;
   assign eff_ref   = ref_vec[hand_q] || (ref_en && (ref_idx == hand_q));

   assign clr_en    = scanning && eff_ref;
   assign clr_idx   = hand_q;
   assign claim_en  = (accept && any_free) || (scanning && !eff_ref);
   assign claim_idx = scanning ? hand_q : free_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= HAND_IDLE;
         hand_q   <= '0;
         done_q   <= 1'b0;
         dirty_q  <= 1'b0;
         placed_q <= 1'b0;
         victim_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (scanning) begin
            hand_q <= hand_next;
            if (!eff_ref) begin
               state_q  <= HAND_IDLE;
               done_q   <= 1'b1;
               victim_q <= hand_q;
               dirty_q  <= mod_vec[hand_q];
               placed_q <= 1'b0;
            end
         end else if (accept) begin
            if (any_free) begin
               done_q   <= 1'b1;
               victim_q <= free_idx;
               dirty_q  <= 1'b0;
               placed_q <= 1'b1;
            end else begin
               state_q <= HAND_SCAN;
            end
         end
      end
   end

   assign busy   = scanning;
   assign done   = done_q;
   assign victim = victim_q;
   assign dirty  = dirty_q;
   assign placed = placed_q;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             ref_en_i,
   input  logic [IDX_W-1:0] ref_frame_i,
   input  logic             ref_write_i,
   input  logic             inv_en_i,
   input  logic [IDX_W-1:0] inv_frame_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] victim_o,
   output logic             dirty_o,
   output logic             placed_o
);
   if (NUM_FRAMES < 2) begin : g_bad_count
      $error("clock_victim_sel: NUM_FRAMES must be at least 2");
   end
   if ((1 << IDX_W) < NUM_FRAMES) begin : g_bad_width
      $error("clock_victim_sel: IDX_W too narrow for NUM_FRAMES");
   end

   logic [NUM_FRAMES-1:0] valid_vec, ref_vec, mod_vec;
   logic                  any_free;
   logic [IDX_W-1:0]      free_idx;
   logic                  clr_en, claim_en;
   logic [IDX_W-1:0]      clr_idx, claim_idx;

   cvs_frame_status #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_en    (ref_en_i),
      .ref_idx   (ref_frame_i),
      .ref_wr    (ref_write_i),
      .inv_en    (inv_en_i),
      .inv_idx   (inv_frame_i),
      .clr_en    (clr_en),
      .clr_idx   (clr_idx),
      .claim_en  (claim_en),
      .claim_idx (claim_idx),
      .valid_vec (valid_vec),
      .ref_vec   (ref_vec),
      .mod_vec   (mod_vec)
   );

   cvs_free_pick #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_free (
      .valid_vec (valid_vec),
      .any_free  (any_free),
      .free_idx  (free_idx)
   );

   cvs_hand_scan #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_i),
      .any_free  (any_free),
      .free_idx  (free_idx),
      .ref_vec   (ref_vec),
      .mod_vec   (mod_vec),
      .ref_en    (ref_en_i),
      .ref_idx   (ref_frame_i),
      .clr_en    (clr_en),
      .clr_idx   (clr_idx),
      .claim_en  (claim_en),
      .claim_idx (claim_idx),
      .busy      (busy_o),
      .done      (done_o),
      .victim    (victim_o),
      .dirty     (dirty_o),
      .placed    (placed_o)
   );
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             done_o,
   input logic [IDX_W-1:0] victim_o,
   input logic             dirty_o,
   input logic             placed_o
);
   int unsigned busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_cnt <= 0;
      else if (busy_o)
         busy_cnt <= busy_cnt + 1;
      else
         busy_cnt <= 0;
   end

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_scan_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !$past(busy_o)) |-> !done_o);

   assert_busy_drop_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o && !placed_o));

   assert_place_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && placed_o) |-> !dirty_o);

   assert_victim_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (int'(victim_o) < NUM_FRAMES));

   assert_scan_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_cnt < 2 * NUM_FRAMES));
endmodule

bind clock_victim_sel cvs_checker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_cvs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .victim_o (victim_o),
   .dirty_o  (dirty_o),
   .placed_o (placed_o)
);

// File: tb/clock_victim_sel_test.sv
`timescale 1ns/1ps
module clock_victim_sel_test;
   localparam int N = 4;
   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_i = 1'b0, ref_en_i = 1'b0, ref_write_i = 1'b0, inv_en_i = 1'b0;
   logic [W-1:0] ref_frame_i = '0, inv_frame_i = '0;
   logic         busy_o, done_o, dirty_o, placed_o;
   logic [W-1:0] victim_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   bit mv[N];
   bit mr[N];
   bit mm[N];
   int mh;

   always #2 clk = ~clk;

   clock_victim_sel #(.NUM_FRAMES(N)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i),
      .ref_en_i(ref_en_i), .ref_frame_i(ref_frame_i), .ref_write_i(ref_write_i),
      .inv_en_i(inv_en_i), .inv_frame_i(inv_frame_i),
      .busy_o(busy_o), .done_o(done_o), .victim_o(victim_o),
      .dirty_o(dirty_o), .placed_o(placed_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_ref(input int f, input bit wr, input bit with_inv);
      @(negedge clk);
      ref_en_i = 1'b1; ref_frame_i = W'(f); ref_write_i = wr;
      inv_en_i = with_inv; inv_frame_i = W'(f);
      @(negedge clk);
      ref_en_i = 1'b0; ref_write_i = 1'b0; inv_en_i = 1'b0;
      if (with_inv) begin
         mv[f] = 0; mr[f] = 0; mm[f] = 0;
      end else begin
         mr[f] = 1;
         if (wr) mm[f] = 1;
      end
   endtask

   // cf: frame referenced during the first scan cycle (-1 for none)
   task automatic do_req(input int cf, input bit poke_busy);
      int ev, ed, ep, el, k, h, cnt;
      bit hit;
      ev = -1; ed = 0; ep = 0; el = 0;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) ev = i;
      if (ev >= 0) begin
         ep = 1; el = 1; mv[ev] = 1; mr[ev] = 0; mm[ev] = 0;
      end else begin
         k = 0; hit = 0;
         while (!hit) begin
            k++;
            h = mh;
            if (mr[h] || (cf == h && k == 1)) begin
               mr[h] = 0;
            end else begin
               hit = 1; ev = h; ed = mm[h]; mr[h] = 0; mm[h] = 0;
            end
            mh = (h + 1) % N;
            if (k == 1 && cf >= 0) mr[cf] = 1;
         end
         el = k + 1;
      end
      @(negedge clk);
      req_i = 1'b1;
      @(negedge clk);
      req_i = poke_busy;
      if (cf >= 0) begin
         ref_en_i = 1'b1; ref_frame_i = W'(cf); ref_write_i = 1'b0;
      end
      cnt = 1;
      while (!done_o && cnt < 4 * N) begin
         if (cnt == 1 && ev >= 0 && ep == 0)
            check("R7 busy during scan", busy_o, 1);
         @(negedge clk);
         req_i = 1'b0; ref_en_i = 1'b0;
         cnt++;
      end
      req_i = 1'b0; ref_en_i = 1'b0;
      check("R8 latency", cnt, el);
      check("R2 R3 R4 R6 victim", victim_o, ev);
      check("R5 dirty", dirty_o, ed);
      check("R2 R3 placed", placed_o, ep);
      check("R2 busy low on placement", busy_o, 0);
      @(negedge clk);
      check("R7 single pulse", done_o, 0);
      check("R7 no restart", busy_o, 0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mr[i] = 0; mm[i] = 0; end
      mh = 0;
      repeat (3) @(negedge clk);
      check("R1 busy at reset", busy_o, 0);
      check("R1 done at reset", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // placements fill frames in index order
      for (int i = 0; i < N; i++) do_req(-1, 0);
      // sweep all referenced patterns with varied written patterns
      for (int p = 0; p < 16; p++) begin
         int wp;
         wp = p ^ (p >> 1);
         for (int f = 0; f < N; f++)
            if (p[f]) do_ref(f, wp[f], 0);
         do_req(-1, (p % 3) == 0);
      end
      // R6: reference collides with the pointer's clear
      for (int rep = 0; rep < 3; rep++) begin
         for (int f = 0; f < N; f++) if (f != mh) do_ref(f, 0, 0);
         do_req(mh, 0);
      end
      do_ref(1, 1, 0);
      do_req((mh + 2) % N, 0);
      // R9: release beats a same-cycle reference
      do_ref(2, 1, 1);
      do_req(-1, 0);
      do_ref(3, 0, 1);
      do_ref(0, 1, 1);
      do_req(-1, 0);
      do_req(-1, 0);
      for (int f = 0; f < N; f++) do_ref(f, f[0], 0);
      do_req(-1, 0);
      do_req(-1, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule